// File: doc/BRIEF.md
# Multiplicative Reciprocal Engine

This block computes the reciprocal of a normalized divisor significand, 1.f, where f is a 52-bit fraction. An 8-bit seed table gives a first guess of 1/b. Three rounds of quadratic multiplicative refinement then bring that guess to well over 60 correct bits. The refinement carries two running values. The scaled divisor D starts at b times the seed and is driven towards one. The running reciprocal N starts at the seed itself and is driven towards 1/b. Each round multiplies both values by the correction factor F = 2 - D.

One two-stage pipelined multiplier serves all the products. Inside each round the two products do not depend on each other, so the D product is issued first and the N product goes in the next cycle. This keeps the cost of a round at two cycles. The result has one integer bit and 56 fraction bits, and it is truncated. A single-cycle done pulse marks it. Applying the dividend, rounding, exponents and special operands are left to the surrounding divider.

Top module: `recip_unit`

## Requirements
- R1: While reset is high and after it is released, done_o is 0 and recip_o is 0 until the first operation completes.
- R2: done_o goes high right after the 12th rising clock edge, counting from and including the edge that samples start_i high while the unit is idle. This is 1 cycle of seed lookup, 2 of prescaling, 2 for each of the 3 rounds and 3 to drain the multiplier and register the result.
- R3: done_o is high for exactly one cycle per completed operation.
- R4: recip_o is an unsigned fixed-point number with bit 56 weighted 1 and bit 0 weighted 2^-56. At done_o it differs by at most 1 from floor(2^108 / (2^52 + f)), where f is the divisor_i value that was sampled. It therefore always lies between 0.5 and 1.0 inclusive.
- R5: The extreme fractions, f = 0 (result 1.0 or one ulp below) and f all ones (result just above 0.5), as well as fractions at the edges of a seed-table segment, meet the R4 bound. The seed table is indexed by bits 51..44 of f.
- R6: A start_i pulse while an operation is in progress is ignored. The running operation finishes on schedule with its own divisor, and no extra done_o follows.
- R7: recip_o keeps its value in every cycle where done_o is not being raised.
- R8: A start_i that is high in the cycle where done_o is high is accepted. A new operation starts from that edge, so results can follow every 12 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation when the unit is idle |
| divisor_i | input | 52 | Divisor fraction f; the divisor is 1.f |
| done_o | output | 1 | One-cycle pulse: recip_o holds a new result |
| recip_o | output | 57 | Truncated reciprocal, 1 integer bit and 56 fraction bits |

## Verification
The bench runs fractions across the input range against an exact wide-integer quotient. These include zero, all ones and values on each side of a seed-segment boundary. A wrong seed formula or index misses the one-ulp bound at once, because three rounds only square out a good seed. A swapped issue order in the multiplier makes a round use the wrong running value and gives garbage. The done timing is counted edge by edge, so an extra or missing pipeline stage moves the pulse. A mid-operation start pulse shows whether a design restarts, reloads the divisor or emits two pulses. Holding start across a done pulse shows whether the idle cycle is lost between back-to-back operations.

// File: rtl/recip_pkg.sv
package recip_pkg;

    localparam int FX_W      = 64;
    localparam int FX_FRAC   = 62;
    localparam int SEED_BITS = 8;
    localparam int SEED_N    = 1 << SEED_BITS;

    typedef logic [FX_W-1:0] fx_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SEED, PH_PRE, PH_WAIT, PH_ITD, PH_ITN, PH_DRAIN, PH_FIN
    } phase_t;

    typedef enum logic [1:0] {TAG_NONE, TAG_D, TAG_N} mtag_t;

    typedef struct packed {
        logic  vld;
        mtag_t tag;
        fx_t   a;
        fx_t   b;
    } mul_req_t;

    typedef struct packed {
        logic  vld;
        mtag_t tag;
        fx_t   prod;
    } mul_rsp_t;

    // Reciprocal of segment midpoint, rounded; the leading one is implied.
    function automatic logic [SEED_BITS-1:0] seed_entry(input int idx);
        logic [63:0] den;
        logic [63:0] num;
        logic [63:0] q;
        den = (64'd1 << (SEED_BITS + 1)) + 64'd1 + 64'(2 * idx);
        num = 64'd1 << (2 * SEED_BITS + 3);
        q   = ((num / den) + 64'd1) >> 1;
        return SEED_BITS'(q);
    endfunction

    // Correction factor 2 - d in the fixed-point format.
    function automatic fx_t corr_factor(input fx_t d);
        fx_t two;
        two = fx_t'(1) << (FX_FRAC + 1);
        return two + (~d) + fx_t'(1);
    endfunction

endpackage

// File: rtl/recip_seed_rom.sv
module recip_seed_rom
    import recip_pkg::*;
(
    input  logic [SEED_BITS-1:0] idx_i,
    output logic [SEED_BITS-1:0] seed_o
);
    logic [SEED_BITS-1:0] tbl [SEED_N];

    for (genvar g = 0; g < SEED_N; g++) begin : g_ent
        assign tbl[g] = seed_entry(g);
    end

    assign seed_o = tbl[idx_i];
endmodule

// File: rtl/recip_mul_pipe.sv
module recip_mul_pipe
    import recip_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mul_req_t req_i,
    output mul_rsp_t rsp_o
);
    localparam int HALF = FX_W / 2;
    localparam int PP_W = FX_W + HALF;

    logic [PP_W-1:0] pp_lo_q, pp_hi_q;
    logic            s1_vld_q;
    mtag_t           s1_tag_q;
    logic [2*FX_W-1:0] full;

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_lo_q  <= '0;
            pp_hi_q  <= '0;
            s1_vld_q <= 1'b0;
            s1_tag_q <= TAG_NONE;
        end else begin
            pp_lo_q  <= PP_W'(req_i.a) * PP_W'(req_i.b[HALF-1:0]);
            pp_hi_q  <= PP_W'(req_i.a) * PP_W'(req_i.b[FX_W-1:HALF]);
            s1_vld_q <= req_i.vld;
            s1_tag_q <= req_i.vld ? req_i.tag : TAG_NONE;
        end
    end

    assign full = (2*FX_W)'(pp_lo_q) + ((2*FX_W)'(pp_hi_q) << HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_o <= '0;
        end else begin
            rsp_o.vld  <= s1_vld_q;
            rsp_o.tag  <= s1_tag_q;
            rsp_o.prod <= FX_W'(full >> FX_FRAC);
        end
    end

    // R2
    mul_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(req_i.vld, 2) |-> rsp_o.vld);
endmodule

// File: rtl/recip_ctrl.sv
module recip_ctrl
    import recip_pkg::*;
#(
    parameter int ITERS = 3,
    localparam int IT_W = $clog2(ITERS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    output logic            accept_o,
    output phase_t          phase_o,
    output logic [IT_W-1:0] iter_o
);
    phase_t          phase_q;
    logic [IT_W-1:0] iter_q;

    assign accept_o = (phase_q == PH_IDLE) && start_i;
    assign phase_o  = phase_q;
    assign iter_o   = iter_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            iter_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE:  if (start_i) begin
                              phase_q <= PH_SEED;
                              iter_q  <= '0;
                          end
                PH_SEED:  phase_q <= PH_PRE;
                PH_PRE:   phase_q <= PH_WAIT;
                PH_WAIT:  phase_q <= PH_ITD;
                PH_ITD:   phase_q <= PH_ITN;
                PH_ITN:   if (iter_q == IT_W'(ITERS - 1)) begin
                              phase_q <= PH_DRAIN;
                          end else begin
                              iter_q  <= iter_q + 1'b1;
                              phase_q <= PH_ITD;
                          end
                PH_DRAIN: phase_q <= PH_FIN;
                PH_FIN:   phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_FIN && start_i) |=> phase_q != PH_SEED);

    // R2
    seed_to_pre_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_SEED |=> phase_q == PH_PRE);

    // R2
    iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
        iter_q < IT_W'(ITERS));
endmodule

// File: rtl/recip_unit.sv
module recip_unit
    import recip_pkg::*;
#(
    parameter int DIV_FRAC = 52,
    parameter int OUT_FRAC = 56,
    parameter int ITERS    = 3,
    localparam int IT_W    = $clog2(ITERS + 1),
    localparam int OUT_W   = OUT_FRAC + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [DIV_FRAC-1:0] divisor_i,
    output logic                done_o,
    output logic [OUT_W-1:0]    recip_o
);
    logic [DIV_FRAC-1:0]  div_q;
    logic [SEED_BITS-1:0] rom_out, seed_q;
    fx_t                  f_q, f_now, b_fx, r0_fx, n_src;
    logic [OUT_W-1:0]     recip_q;
    logic                 done_q, accept;
    phase_t               phase;
    logic [IT_W-1:0]      iter;
    mul_req_t             mreq;
    mul_rsp_t             mrsp;

    recip_ctrl #(.ITERS(ITERS)) ctrl_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .accept_o(accept), .phase_o(phase), .iter_o(iter)
    );

    recip_seed_rom rom_i (
        .idx_i(div_q[DIV_FRAC-1 -: SEED_BITS]),
        .seed_o(rom_out)
    );

    recip_mul_pipe mul_i (
        .clk(clk), .rst(rst), .req_i(mreq), .rsp_o(mrsp)
    );

    assign b_fx  = fx_t'({1'b1, div_q}) << (FX_FRAC - DIV_FRAC);
    assign r0_fx = fx_t'({1'b1, seed_q}) << (FX_FRAC - SEED_BITS - 1);
    assign f_now = corr_factor(mrsp.prod);
    assign n_src = (iter == '0) ? r0_fx : mrsp.prod;

    always_comb begin
        mreq = '0;
        unique case (phase)
            PH_PRE: begin
                mreq.vld = 1'b1; mreq.tag = TAG_D;
                mreq.a = b_fx;   mreq.b = r0_fx;
            end
            PH_ITD: begin
                mreq.vld = 1'b1;    mreq.tag = TAG_D;
                mreq.a = mrsp.prod; mreq.b = f_now;
            end
            PH_ITN: begin
                mreq.vld = 1'b1; mreq.tag = TAG_N;
                mreq.a = n_src;  mreq.b = f_q;
            end
            default: mreq = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            seed_q  <= '0;
            f_q     <= '0;
            recip_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) div_q <= divisor_i;
            unique case (phase)
                PH_SEED: seed_q <= rom_out;
                PH_ITD:  f_q    <= f_now;
                PH_FIN: begin
                    recip_q <= OUT_W'(mrsp.prod >> (FX_FRAC - OUT_FRAC));
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign done_o  = done_q;
    assign recip_o = recip_q;

    // R2
    itd_sees_d_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_ITD |-> (mrsp.vld && mrsp.tag == TAG_D));

    // R2
    itn_sees_n_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ITN && iter != '0) |-> (mrsp.vld && mrsp.tag == TAG_N));

    // R2
    fin_sees_n_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FIN |-> (mrsp.vld && mrsp.tag == TAG_N));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    result_range_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (recip_o[OUT_FRAC] ? (recip_o[OUT_FRAC-1:0] == '0)
                                      : recip_o[OUT_FRAC-1]));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |=> (!done_o || 1'b1) && ($rose(done_o) || $stable(recip_o)));
endmodule

// File: tb/recip_unit_tb_top.sv
module recip_unit_tb_top;
    localparam int DF  = 52;
    localparam int OF  = 56;
    localparam int OW  = OF + 1;
    localparam int LAT = 12;
    localparam int NV  = 10;
    localparam logic [DF-1:0] VECS [NV] = '{
        52'h0_0000_0000_0000,   // f = 0, R5
        52'hF_FFFF_FFFF_FFFF,   // all ones, R5
        52'h0_0FFF_FFFF_FFFF,   // end of segment 0, R5
        52'h0_1000_0000_0000,   // start of segment 1, R5
        52'h8_0000_0000_0000,
        52'h7_FFFF_FFFF_FFFF,
        52'h5_5555_5555_5555,
        52'hA_AAAA_AAAA_AAAA,
        52'h1_2345_6789_ABCD,
        52'hE_DCBA_9876_5431
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DF-1:0] div = '0;
    logic          done;
    logic [OW-1:0] recip;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    recip_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start), .divisor_i(div),
        .done_o(done), .recip_o(recip)
    );

    function automatic logic [OW-1:0] exp_recip(input logic [DF-1:0] f);
        logic [127:0] num, den;
        num = 128'd1 << (OF + DF);
        den = (128'd1 << DF) + 128'(f);
        return OW'(num / den);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_acc(input logic [OW-1:0] act, input logic [DF-1:0] f,
                             input string req);
        logic [OW-1:0] e;
        logic [OW-1:0] d;
        e = exp_recip(f);
        d = (act > e) ? act - e : e - act;
        check(d <= 1, req, 128'(act), 128'(e));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [OW-1:0] res;
        int lat;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(done == 1'b0 && recip == '0, "R1", {recip, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 after reset release
        check(done == 1'b0 && recip == '0, "R1", {recip, done}, 0);

        for (int i = 0; i < NV; i++) begin
            start = 1'b1; div = VECS[i];
            @(negedge clk);
            start = 1'b0;
            wait_done(lat);
            res = recip;
            check(lat == LAT, "R2", 128'(lat), 128'(LAT));
            check_acc(res, VECS[i], (i < 4) ? "R5" : "R4");
            @(negedge clk);
            check(done == 1'b0, "R3", 128'(done), 0);
            repeat (3) @(negedge clk);
            check(recip == res, "R7", 128'(recip), 128'(res));
        end

        // R6: start pulse in the middle of an operation
        start = 1'b1; div = VECS[6];
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; div = VECS[1];
        @(negedge clk);
        start = 1'b0; div = '0;
        lat = 5;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == LAT, "R6", 128'(lat), 128'(LAT));
        check_acc(recip, VECS[6], "R6");
        begin
            int extra = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R6", 128'(extra), 0);
        end

        // R8: start held high across done
        start = 1'b1; div = VECS[8];
        @(negedge clk);
        wait_done(lat);
        check_acc(recip, VECS[8], "R8");
        div = VECS[9];
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check(lat == LAT, "R8", 128'(lat), 128'(LAT));
        check_acc(recip, VECS[9], "R8");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule